// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns a stream of frame bytes into a single serial bit stream. It sends one bit on each cycle in which the bit-clock enable is high. Bytes arrive over a valid/ready interface that carries an end-of-frame marker. A start request begins a frame, and the first byte is taken in the same cycle. The framing is set from static configuration inputs, which are captured when the frame starts.

There are three framings. In the contention-style framing, an alternating preamble is sent first, and its final two bits form the start-of-frame marker. The payload follows, then the CRC. In the HDLC-style framing, an optional preamble comes first, then an opening flag, the payload and the CRC with zero-bit insertion, and then a closing flag. In raw framing, only the payload bits are sent. In raw framing the serial output is also fed back to the receive-side data output as a loopback test path.

The CRC is either a 16-bit or a 32-bit code, chosen at run time. A separate output marks which transmitted bits belong to the address field, which is one or two bytes long.

Top module: `sftx_top`

## Requirements
- R1: After reset, `tx_out` is 1, `tx_busy` is 0 and `tx_done` is 0. The line stays at 1 whenever the block is not busy.
- R2: `cfg_pre_len` sets the preamble length: code 0 gives 0 bits, 1 gives 8, 2 gives 32 and 3 gives 64. Preamble bit k is 1 for even k and 0 for odd k. Raw framing sends no preamble.
- R3: When `cfg_sdlc`=0 and `cfg_raw`=0 (contention framing), the last two preamble bits are both 1 and count toward the programmed length. The payload follows directly, with no flags and no zero insertion.
- R4: `cfg_err` is high exactly when `cfg_raw`=0, `cfg_sdlc`=0 and `cfg_pre_len`=0. While it is high, `tx_start` is refused: `in_ready` stays 0, no byte is taken and `tx_busy` stays 0.
- R5: When `cfg_sdlc`=1 and `cfg_raw`=0, the flag 0,1,1,1,1,1,1,0 (in sending order) is sent after the preamble and again after the CRC. Flags are never stuffed.
- R6: In HDLC-style framing, a 0 is inserted after every run of five 1s among the payload and CRC bits. This includes a run that ends on the final CRC bit.
- R7: Payload bytes are sent least significant bit first, in the order they were accepted.
- R8: `cfg_crc32`=0 selects the reflected CCITT code (polynomial 0x8408 in reflected form, preset 0xFFFF). `cfg_crc32`=1 selects the reflected 32-bit code (0xEDB88320, preset 0xFFFFFFFF). The final register is inverted and sent LSB first after the payload. The CRC covers only the payload.
- R9: With `cfg_raw`=1, only the payload bits are sent, and `rx_data` equals `tx_out`. With `cfg_raw`=0, `rx_data` equals `rx_line`.
- R10: `tx_addr` is 1 while `tx_out` carries a bit of the address field. The address field is the first byte when `cfg_addr16`=0 and the first two bytes when it is 1. Zero bits inserted inside that field are included.
- R11: `tx_out` changes only on a cycle with `bit_en` high. The first bit appears at the first `bit_en` after the start. `tx_busy` falls, and `tx_done` pulses for one cycle, at the `bit_en` after the last frame bit.
- R12: The first byte is taken together with an accepted `tx_start`. Each later byte is taken on the `bit_en` that sends bit 7 of the previous byte. No byte is taken after the one marked `in_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sdlc | input | 1 | 1 selects HDLC-style framing, 0 selects contention framing |
| cfg_raw | input | 1 | 1 selects raw framing with loopback |
| cfg_crc32 | input | 1 | 1 selects the 32-bit CRC, 0 the 16-bit CRC |
| cfg_addr16 | input | 1 | 1 selects a two-byte address field |
| cfg_pre_len | input | 2 | Preamble length code |
| tx_start | input | 1 | Request to begin a frame |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | Frame byte valid |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Byte accepted when high together with `in_valid` |
| bit_en | input | 1 | Bit-clock enable |
| tx_out | output | 1 | Serial output |
| tx_addr | output | 1 | Current serial bit is in the address field |
| tx_busy | output | 1 | Frame in progress |
| tx_done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | Illegal configuration (contention framing with zero preamble) |
| rx_line | input | 1 | Receive line from the pad side |
| rx_data | output | 1 | Receive data toward the receiver |

## Verification
The bench uses payloads packed with 1s, so that runs of five 1s cross byte boundaries, reach the CRC, and end on the final CRC bit. A design that counted flags toward the run, reset the count per byte, or skipped the trailing insertion would emit a wrong closing sequence. Two frames carry a standard nine-character check string with fixed, published CRC results. A wrong preset, polynomial, bit order or missing inversion would therefore corrupt the tail of the frame. Each preamble code is exercised, including the start marker that replaces the last two pattern bits. An off-by-one in the length count would shift every later bit. The refused-start case and the loopback mux are checked at the ports, as is the address marking across a two-byte field.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    localparam int          FLAG_BITS = 8;
    localparam logic [7:0]  FLAG_PAT  = 8'h7E;
    localparam logic [31:0] POLY16    = 32'h0000_8408;
    localparam logic [31:0] POLY32    = 32'hEDB8_8320;
    localparam logic [31:0] INIT16    = 32'h0000_FFFF;
    localparam logic [31:0] INIT32    = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_OFLAG, ST_DATA, ST_CRC, ST_CFLAG, ST_FIN
    } tx_state_e;

    typedef enum logic [1:0] {
        MODE_CSMA, MODE_SDLC, MODE_RAW
    } tx_mode_e;

    typedef struct packed {
        tx_mode_e   mode;
        logic       crc32;
        logic       addr16;
        logic [6:0] pre_bits;
    } tx_cfg_t;

    function automatic logic [6:0] pre_len_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 7'd0;
            2'd1:    return 7'd8;
            2'd2:    return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

    function automatic logic [6:0] crc_len(input logic wide);
        return wide ? 7'd32 : 7'd16;
    endfunction

    function automatic logic [31:0] crc_step(input logic [31:0] r, input logic b, input logic wide);
        logic fb;
        fb = r[0] ^ b;
        return (r >> 1) ^ (fb ? (wide ? POLY32 : POLY16) : 32'h0);
    endfunction

endpackage

// File: rtl/sftx_crc.sv
module sftx_crc
    import sftx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic wide,
    input  logic step_en,
    input  logic din,
    input  logic shift_en,
    output logic crc_lsb
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else if (init) begin
            crc_q <= wide ? INIT32 : INIT16;
        end else if (step_en) begin
            crc_q <= crc_step(crc_q, din, wide);
        end else if (shift_en) begin
            crc_q <= crc_q >> 1;
        end
    end

    assign crc_lsb = crc_q[0];
endmodule

// File: rtl/sftx_stuff.sv
module sftx_stuff #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic cnt_en,
    input  logic din,
    output logic need
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] ones_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ones_q <= '0;
        end else if (cnt_en) begin
            ones_q <= din ? ones_q + 1'b1 : '0;
        end
    end

    assign need = (ones_q == CW'(RUN_LEN));
endmodule

// File: rtl/sftx_top.sv
module sftx_top
    import sftx_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int RUN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sdlc,
    input  logic              cfg_raw,
    input  logic              cfg_crc32,
    input  logic              cfg_addr16,
    input  logic [1:0]        cfg_pre_len,
    input  logic              tx_start,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              bit_en,
    output logic              tx_out,
    output logic              tx_addr,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              cfg_err,
    input  logic              rx_line,
    output logic              rx_data
);
    localparam int IDX_W = $clog2(BYTE_W);

    tx_state_e         st;
    tx_cfg_t           cfg_q;
    logic [6:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic              last_q;
    logic [IDX_W-1:0]  bidx;
    logic [1:0]        byte_no;
    logic              tx_q, adr_q, done_q;

    logic is_sdlc, is_csma, is_raw;
    logic stuff_need, crc_lsb;
    logic stuff_now, need_byte, adv, cur_bit, start_ok, start_fire;
    logic [1:0] addr_bytes;

    assign is_sdlc    = (cfg_q.mode == MODE_SDLC);
    assign is_csma    = (cfg_q.mode == MODE_CSMA);
    assign is_raw     = (cfg_q.mode == MODE_RAW);
    assign addr_bytes = cfg_q.addr16 ? 2'd2 : 2'd1;

    always_comb begin
        cfg_err    = !cfg_raw && !cfg_sdlc && (cfg_pre_len == 2'd0);
        start_ok   = (st == ST_IDLE) && tx_start && !cfg_err;
        start_fire = start_ok && in_valid;
        stuff_now  = is_sdlc && stuff_need &&
                     ((st == ST_DATA) || (st == ST_CRC) || ((st == ST_CFLAG) && (cnt == 7'd0)));
        need_byte  = (st == ST_DATA) && !stuff_now &&
                     (bidx == IDX_W'(BYTE_W - 1)) && !last_q;
        adv        = bit_en && (st != ST_IDLE) && !(need_byte && !in_valid);
        in_ready   = start_ok || (bit_en && need_byte);
    end

    always_comb begin
        cur_bit = 1'b1;
        case (st)
            ST_PRE:   cur_bit = (is_csma && (cnt >= cfg_q.pre_bits - 7'd2)) ? 1'b1 : ~cnt[0];
            ST_OFLAG: cur_bit = FLAG_PAT[cnt[2:0]];
            ST_DATA:  cur_bit = stuff_now ? 1'b0 : sh[0];
            ST_CRC:   cur_bit = stuff_now ? 1'b0 : ~crc_lsb;
            ST_CFLAG: cur_bit = stuff_now ? 1'b0 : FLAG_PAT[cnt[2:0]];
            default:  cur_bit = 1'b1;
        endcase
    end

    sftx_crc u_crc (
        .clk      (clk),
        .rst      (rst),
        .init     (start_fire),
        .wide     (start_fire ? cfg_crc32 : cfg_q.crc32),
        .step_en  (adv && (st == ST_DATA) && !stuff_now && !is_raw),
        .din      (sh[0]),
        .shift_en (adv && (st == ST_CRC) && !stuff_now),
        .crc_lsb  (crc_lsb)
    );

    sftx_stuff #(.RUN_LEN(RUN_LEN)) u_stuff (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_fire || (adv && stuff_now)),
        .cnt_en (adv && !stuff_now && is_sdlc && ((st == ST_DATA) || (st == ST_CRC))),
        .din    (cur_bit),
        .need   (stuff_need)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cfg_q   <= '{mode: MODE_CSMA, crc32: 1'b0, addr16: 1'b0, pre_bits: 7'd0};
            cnt     <= '0;
            sh      <= '0;
            last_q  <= 1'b0;
            bidx    <= '0;
            byte_no <= '0;
            tx_q    <= 1'b1;
            adr_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_fire) begin
                cfg_q.mode     <= cfg_raw ? MODE_RAW : (cfg_sdlc ? MODE_SDLC : MODE_CSMA);
                cfg_q.crc32    <= cfg_crc32;
                cfg_q.addr16   <= cfg_addr16;
                cfg_q.pre_bits <= pre_len_bits(cfg_pre_len);
                sh      <= in_data;
                last_q  <= in_last;
                cnt     <= '0;
                bidx    <= '0;
                byte_no <= '0;
                if (cfg_raw)
                    st <= ST_DATA;
                else if (cfg_pre_len == 2'd0)
                    st <= ST_OFLAG;
                else
                    st <= ST_PRE;
            end else if (adv) begin
                tx_q  <= cur_bit;
                adr_q <= (st == ST_DATA) && (byte_no < addr_bytes);
                if (!stuff_now) begin
                    case (st)
                        ST_PRE: begin
                            if (cnt == cfg_q.pre_bits - 7'd1) begin
                                cnt <= '0;
                                st  <= is_sdlc ? ST_OFLAG : ST_DATA;
                            end else begin
                                cnt <= cnt + 7'd1;
                            end
                        end
                        ST_OFLAG: begin
                            if (cnt == 7'(FLAG_BITS - 1)) begin
                                cnt <= '0;
                                st  <= ST_DATA;
                            end else begin
                                cnt <= cnt + 7'd1;
                            end
                        end
                        ST_DATA: begin
                            sh   <= sh >> 1;
                            bidx <= bidx + 1'b1;
                            if (bidx == IDX_W'(BYTE_W - 1)) begin
                                bidx <= '0;
                                if (byte_no != 2'd3) byte_no <= byte_no + 2'd1;
                                if (last_q) begin
                                    cnt <= '0;
                                    st  <= is_raw ? ST_FIN : ST_CRC;
                                end else begin
                                    sh     <= in_data;
                                    last_q <= in_last;
                                end
                            end
                        end
                        ST_CRC: begin
                            if (cnt == crc_len(cfg_q.crc32) - 7'd1) begin
                                cnt <= '0;
                                st  <= is_sdlc ? ST_CFLAG : ST_FIN;
                            end else begin
                                cnt <= cnt + 7'd1;
                            end
                        end
                        ST_CFLAG: begin
                            if (cnt == 7'(FLAG_BITS - 1)) begin
                                cnt <= '0;
                                st  <= ST_FIN;
                            end else begin
                                cnt <= cnt + 7'd1;
                            end
                        end
                        ST_FIN: begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assign tx_out  = tx_q;
    assign tx_addr = adr_q;
    assign tx_busy = (st != ST_IDLE);
    assign tx_done = done_q;
    assign rx_data = cfg_raw ? tx_q : rx_line;

endmodule

// File: rtl/sftx_chk.sv
module sftx_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic in_valid,
    input logic in_ready,
    input logic tx_out,
    input logic tx_busy,
    input logic tx_done,
    input logic cfg_err
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    // R11
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (!tx_busy && $past(tx_busy)));

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_out);

    // R11
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_out));

    // R4
    refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !tx_busy) |=> !tx_busy);

    // R12
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy && in_valid && in_ready) |=> tx_busy);
endmodule

bind sftx_top sftx_chk u_sftx_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_out   (tx_out),
    .tx_busy  (tx_busy),
    .tx_done  (tx_done),
    .cfg_err  (cfg_err)
);

// File: tb/sftx_top_bench.sv
module sftx_top_bench;
    localparam int CLK_PERIOD = 10;

    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_sdlc = 1'b0, cfg_raw = 1'b0, cfg_crc32 = 1'b0, cfg_addr16 = 1'b0;
    logic [1:0] cfg_pre_len = 2'd1;
    logic tx_start = 1'b0;
    logic [7:0] in_data = '0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic in_ready;
    logic bit_en = 1'b0;
    logic tx_out, tx_addr, tx_busy, tx_done, cfg_err;
    logic rx_line = 1'b0;
    logic rx_data;

    sftx_top u_sftx_top (
        .clk(clk), .rst(rst), .cfg_sdlc(cfg_sdlc), .cfg_raw(cfg_raw),
        .cfg_crc32(cfg_crc32), .cfg_addr16(cfg_addr16), .cfg_pre_len(cfg_pre_len),
        .tx_start(tx_start), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .bit_en(bit_en), .tx_out(tx_out), .tx_addr(tx_addr),
        .tx_busy(tx_busy), .tx_done(tx_done), .cfg_err(cfg_err),
        .rx_line(rx_line), .rx_data(rx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int ones = 0;
    logic   exp_bit[$];
    logic   exp_adr[$];
    string  exp_tag[$];
    logic [7:0] feed_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bit-clock enable: one cycle in four
    int be_div = 0;
    always @(negedge clk) begin
        be_div = (be_div + 1) % 4;
        bit_en <= (be_div == 3) && !rst;
    end

    // byte source (valid/ready)
    bit take = 1'b0;
    always begin
        @(negedge clk);
        if (take && feed_q.size() > 0) void'(feed_q.pop_front());
        take = 1'b0;
        in_valid = (feed_q.size() > 0);
        in_data  = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
        in_last  = (feed_q.size() == 1);
        #(CLK_PERIOD/2 - 1);
        take = in_valid && in_ready;
    end

    // monitor / scoreboard
    always begin
        logic be;
        @(posedge clk);
        be = bit_en;
        #(CLK_PERIOD/4);
        if (!rst) begin
            if (be && tx_busy) begin
                if (exp_bit.size() == 0) begin
                    chk(1'b0, "R11 extra bit", 32'(tx_out), 32'h0);
                end else begin
                    logic b, a;
                    string t;
                    b = exp_bit.pop_front();
                    a = exp_adr.pop_front();
                    t = exp_tag.pop_front();
                    chk(tx_out === b, t, 32'(tx_out), 32'(b));
                    chk(tx_addr === a, "R10 address marking", 32'(tx_addr), 32'(a));
                end
            end
            if (tx_busy)
                chk(rx_data === (cfg_raw ? tx_out : rx_line), "R9 receive path", 32'(rx_data),
                    32'(cfg_raw ? tx_out : rx_line));
            if (tx_done) begin
                chk(exp_bit.size() == 0, "R11 early end", 32'(exp_bit.size()), 32'h0);
                done_cnt++;
            end
        end
    end

    task automatic push_exp(input logic b, input logic a, input string t, input bit stf, input logic sa);
        exp_bit.push_back(b);
        exp_adr.push_back(a);
        exp_tag.push_back(t);
        if (stf) begin
            ones = b ? ones + 1 : 0;
            if (ones == 5) begin
                exp_bit.push_back(1'b0);
                exp_adr.push_back(sa);
                exp_tag.push_back("R6 inserted zero");
                ones = 0;
            end
        end
    endtask

    function automatic logic [31:0] crc_ref(input bq_t d, input bit wide);
        logic [31:0] r;
        logic fb;
        r = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        foreach (d[i]) begin
            for (int j = 0; j < 8; j++) begin
                fb = r[0] ^ d[i][j];
                r = r >> 1;
                if (fb) r = r ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
            end
        end
        return wide ? ~r : {16'h0, ~r[15:0]};
    endfunction

    task automatic run_frame(input bit sdlc, input bit raw, input bit c32, input bit a16,
                             input logic [1:0] pl, input bq_t d, input bit known, input logic [31:0] kcrc);
        int n, ab, w, start_cnt, dbits;
        logic [7:0] flag;
        logic [31:0] cv;
        flag = 8'h7E;
        cfg_sdlc = sdlc; cfg_raw = raw; cfg_crc32 = c32; cfg_addr16 = a16; cfg_pre_len = pl;
        ones = 0;
        ab = a16 ? 2 : 1;
        n = (pl == 0) ? 0 : (pl == 1) ? 8 : (pl == 2) ? 32 : 64;
        if (!raw) begin
            for (int k = 0; k < n; k++) begin
                if (!sdlc && k >= n - 2) push_exp(1'b1, 1'b0, "R3 start marker", 1'b0, 1'b0);
                else push_exp((k % 2) == 0, 1'b0, "R2 preamble", 1'b0, 1'b0);
            end
            if (sdlc) for (int k = 0; k < 8; k++) push_exp(flag[k], 1'b0, "R5 opening flag", 1'b0, 1'b0);
        end
        dbits = 0;
        foreach (d[i]) begin
            for (int j = 0; j < 8; j++) begin
                dbits++;
                push_exp(d[i][j], (i < ab), raw ? "R9 raw payload" : "R7 payload",
                         sdlc && !raw, ((dbits / 8) < ab));
            end
        end
        if (!raw) begin
            cv = known ? kcrc : crc_ref(d, c32);
            w = c32 ? 32 : 16;
            for (int j = 0; j < w; j++) push_exp(cv[j], 1'b0, "R8 crc", sdlc, 1'b0);
            if (sdlc) for (int k = 0; k < 8; k++) push_exp(flag[k], 1'b0, "R5 closing flag", 1'b0, 1'b0);
        end
        foreach (d[i]) feed_q.push_back(d[i]);
        start_cnt = done_cnt;
        @(negedge clk);
        @(negedge clk);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        while (done_cnt == start_cnt) @(negedge clk);
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(!tx_done, "R11 done width", 32'(tx_done), 32'h0);
        chk(!tx_busy && tx_out, "R1 idle after frame", {30'h0, tx_busy, tx_out}, 32'h1);
        chk(feed_q.size() == 0, "R12 bytes consumed", 32'(feed_q.size()), 32'h0);
        exp_bit.delete(); exp_adr.delete(); exp_tag.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bq_t s;
        s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        // R1 reset state
        chk(tx_out === 1'b1, "R1 reset line", 32'(tx_out), 32'h1);
        chk(tx_busy === 1'b0, "R1 reset busy", 32'(tx_busy), 32'h0);
        chk(tx_done === 1'b0, "R1 reset done", 32'(tx_done), 32'h0);

        // R2 R3 R7 R8: contention framing, 8-bit preamble, 16-bit check value
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, s, 1'b1, 32'h0000_906E);
        // R2 R3 R8 R10: 32-bit preamble, 32-bit check value, two-byte address
        run_frame(1'b0, 1'b0, 1'b1, 1'b1, 2'd2, s, 1'b1, 32'hCBF4_3926);
        // R5 R6 R10: HDLC-style, no preamble, dense ones
        run_frame(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, '{8'hFF, 8'hFF, 8'h7E, 8'h01, 8'hF8}, 1'b0, 32'h0);
        // R2 R5 R6 R8: 64-bit preamble, 32-bit CRC
        run_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'd3, '{8'h1F, 8'hF0, 8'h3E}, 1'b0, 32'h0);
        // R6 run ending on the last payload bit and crossing into the CRC
        run_frame(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, '{8'hF0, 8'hFF}, 1'b0, 32'h0);
        // R9 raw framing with loopback
        run_frame(1'b0, 1'b1, 1'b0, 1'b1, 2'd0, '{8'hA5, 8'h3C, 8'hFF}, 1'b0, 32'h0);

        // R4 illegal configuration refuses the start
        @(negedge clk);
        cfg_raw = 1'b0; cfg_sdlc = 1'b0; cfg_pre_len = 2'd0;
        feed_q.push_back(8'h55);
        @(negedge clk);
        @(negedge clk);
        chk(cfg_err === 1'b1, "R4 error flag", 32'(cfg_err), 32'h1);
        tx_start = 1'b1;
        repeat (3) begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            chk(in_ready === 1'b0, "R4 no byte taken", 32'(in_ready), 32'h0);
        end
        repeat (8) @(negedge clk);
        tx_start = 1'b0;
        chk(tx_busy === 1'b0, "R4 no frame", 32'(tx_busy), 32'h0);
        chk(tx_out === 1'b1, "R4 line idle", 32'(tx_out), 32'h1);
        chk(feed_q.size() == 1, "R4 byte kept", 32'(feed_q.size()), 32'h1);
        feed_q.delete();
        cfg_sdlc = 1'b1;
        @(negedge clk);
        chk(cfg_err === 1'b0, "R4 zero preamble legal in HDLC-style", 32'(cfg_err), 32'h0);
        cfg_sdlc = 1'b0; cfg_raw = 1'b1;
        @(negedge clk);
        chk(cfg_err === 1'b0, "R4 zero preamble legal in raw", 32'(cfg_err), 32'h0);
        rx_line = 1'b1;
        #1;
        chk(rx_data === tx_out, "R9 loopback idle", 32'(rx_data), 32'(tx_out));
        cfg_raw = 1'b0; rx_line = 1'b0;
        #1;
        chk(rx_data === 1'b0, "R9 line path", 32'(rx_data), 32'h0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule